// File: doc/BRIEF.md
# Configuration Save/Restore Controller

This block owns a 96-bit live configuration register and a non-volatile shadow copy of it. The shadow is modelled as a register array whose contents persist across the synchronous reset. The serial-bus slave that sits in front of the block reports bus events to it as single-cycle strobes: a START, a command byte, any further data byte, and a STOP. It also hands over a complete 96-bit programming word whenever a full write has been committed. From these strobes the controller recognises two-byte save and restore commands and starts them only once STOP arrives. It times each operation with a parameterised cycle count, and while it is busy it raises a flag that tells the slave to withhold acknowledges, including the acknowledge of its own address.

After reset the register reads all zeros and the acknowledge-inhibit flag stays high. The first cycle in which the power-good input is high starts an automatic restore from the shadow. When that restore completes, the register takes the stored value in a single step and the device starts answering the bus. Commanded operations are accepted only while power is good, the PLL-disable pin is low and the register's hold bit is clear. The automatic restore ignores both of the last two conditions.

Top module: `cfg_store_ctrl`

## Requirements
- R1: From reset until the automatic restore completes, `cfg_q` is all zeros, `ack_inhibit` is 1, `boot_done` is 0, and `prog_load` has no effect.
- R2: The automatic restore starts at the first clock edge after reset at which `pwr_up` is 1, whatever the values of `pll_disable` and `cfg_q[57]`. `BOOT_CYC` clock edges later it loads the shadow into `cfg_q`, drops `ack_inhibit` and raises `boot_done`, all at the same edge.
- R3: When `ack_inhibit` is 0, a `prog_load` strobe writes `prog_data` into `cfg_q` at that clock edge.
- R4: A save is a START, a command byte equal to `SAVE_CODE` (default 8'hA5), and then STOP with no data byte in between. `ack_inhibit` rises at the edge that samples the STOP and stays high for exactly `SAVE_CYC` cycles. At the final edge the shadow takes the value of `cfg_q`.
- R5: A restore uses the same framing with `RESTORE_CODE` (default 8'h5A) and holds `ack_inhibit` high for `RESTORE_CYC` cycles. `cfg_q` keeps its old value until the final edge, at which all 96 bits are replaced by the shadow together.
- R6: A commanded save or restore is accepted only if `pwr_up`=1, `pll_disable`=0 and `cfg_q[57]`=0 in the STOP cycle. Otherwise it is dropped: `ack_inhibit` stays 0 and neither `cfg_q` nor the shadow changes.
- R7: The following are ignored: a command byte of any other value; a command that is followed by a data byte before STOP; and a command that is followed by a new START before STOP.
- R8: While `ack_inhibit` is 1, `prog_load`, command bytes and STOP have no effect. A command byte seen while busy does not arm a later STOP.
- R9: A `prog_load` in the same cycle as an accepted STOP is applied. The enable check uses the register value from before that load, and a save started in that cycle stores the newly loaded value.
- R10: The shadow is not cleared by `rst`. The automatic restore after a reset returns the value most recently saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | Power-good; 1 when the device is not powered down |
| pll_disable | input | 1 | 1 when the PLL is disabled by its pin |
| start_pulse | input | 1 | Bus START seen |
| cmd_pulse | input | 1 | Command byte received after the write address |
| cmd_code | input | 8 | Command byte value, valid with cmd_pulse |
| data_pulse | input | 1 | A further data byte received |
| stop_pulse | input | 1 | Bus STOP seen |
| prog_load | input | 1 | Committed full programming write |
| prog_data | input | 96 | Value committed with prog_load |
| cfg_q | output | 96 | Live configuration register |
| ack_inhibit | output | 1 | 1 while the slave must not acknowledge |
| boot_done | output | 1 | Automatic restore has completed |

## Verification
Two functions can fall in the same clock edge: a committed programming write and the STOP that starts a save. The bench drives `prog_load` and `stop_pulse` in one cycle, with the old register value holding bit 57 clear and the new value holding it set. It judges the outcome in three ways. The save must still be accepted, `cfg_q` must show the new value, and after a reset the automatic restore must bring that same new value back out of the shadow. A behavioural model compares `cfg_q`, `ack_inhibit` and `boot_done` on every cycle throughout.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_BOOT    = 2'd3
  } op_e;
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_store_pkg::*;
#(
  parameter int                CODE_W       = 8,
  parameter logic [CODE_W-1:0] SAVE_CODE    = 8'hA5,
  parameter logic [CODE_W-1:0] RESTORE_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inhibit,
  input  logic              enable_ok,
  input  logic              start_pulse,
  input  logic              cmd_pulse,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              data_pulse,
  input  logic              stop_pulse,
  output op_e               op_req
);
  logic              armed_q;
  logic [CODE_W-1:0] code_q;

  // A command is armed only by a command byte seen while the device answers;
  // any other bus event before STOP disarms it.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      code_q  <= '0;
    end else if (inhibit || start_pulse || data_pulse || stop_pulse) begin
      armed_q <= 1'b0;
    end else if (cmd_pulse) begin
      armed_q <= 1'b1;
      code_q  <= cmd_code;
    end
  end

  always_comb begin
    op_req = OP_NONE;
    if (stop_pulse && armed_q && !inhibit && enable_ok) begin
      if (code_q == SAVE_CODE)         op_req = OP_SAVE;
      else if (code_q == RESTORE_CODE) op_req = OP_RESTORE;
    end
  end

  p_disarm_on_stop_r7: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !armed_q);
  p_busy_never_arms_r8: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !armed_q);
endmodule

// File: rtl/cfg_dur_timer.sv
module cfg_dur_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign running = (cnt_q != '0);
  assign expire  = (cnt_q == CNT_W'(1));

  p_no_reload_busy_r8: assert property (@(posedge clk) disable iff (rst)
    running |-> !load);
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/cfg_nv_store.sv
module cfg_nv_store #(
  parameter int               W    = 96,
  parameter int               LANE = 8,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  localparam int NLANE = W / LANE;

  // One register per lane; initial contents stand in for the stored image
  // and survive the logic reset.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE-1:0] lane_q = INIT[g*LANE +: LANE];
    always_ff @(posedge clk) begin
      if (we) lane_q <= wdata[g*LANE +: LANE];
    end
    assign rdata[g*LANE +: LANE] = lane_q;
  end

  initial begin
    a_lane_fit_r10: assert (W % LANE == 0);
  end
endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int                CFG_W        = 96,
  parameter int                CODE_W       = 8,
  parameter int                LANE_W       = 8,
  parameter int                HOLD_BIT     = 57,
  parameter logic [CODE_W-1:0] SAVE_CODE    = 8'hA5,
  parameter logic [CODE_W-1:0] RESTORE_CODE = 8'h5A,
  parameter int                BOOT_CYC     = 375000,
  parameter int                SAVE_CYC     = 9000000,
  parameter int                RESTORE_CYC  = 1250000,
  parameter logic [CFG_W-1:0]  STORE_INIT   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up,
  input  logic              pll_disable,
  input  logic              start_pulse,
  input  logic              cmd_pulse,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              data_pulse,
  input  logic              stop_pulse,
  input  logic              prog_load,
  input  logic [CFG_W-1:0]  prog_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              ack_inhibit,
  output logic              boot_done
);
  localparam int MAX_SR  = (SAVE_CYC > RESTORE_CYC) ? SAVE_CYC : RESTORE_CYC;
  localparam int MAX_CYC = (BOOT_CYC > MAX_SR) ? BOOT_CYC : MAX_SR;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CFG_W-1:0] cfg_r;
  logic             inhibit_q;
  logic             boot_done_q;
  op_e              op_q;
  op_e              op_req;
  logic             enable_ok;
  logic             boot_go;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_running;
  logic             t_expire;
  logic [CFG_W-1:0] nv_rdata;
  logic             nv_we;

  assign enable_ok = pwr_up && !pll_disable && !cfg_r[HOLD_BIT];
  assign boot_go   = !boot_done_q && (op_q == OP_NONE) && pwr_up;
  assign t_load    = boot_go || (op_req != OP_NONE);

  always_comb begin
    if (boot_go)                t_val = CNT_W'(BOOT_CYC);
    else if (op_req == OP_SAVE) t_val = CNT_W'(SAVE_CYC);
    else                        t_val = CNT_W'(RESTORE_CYC);
  end

  cfg_cmd_decode #(
    .CODE_W      (CODE_W),
    .SAVE_CODE   (SAVE_CODE),
    .RESTORE_CODE(RESTORE_CODE)
  ) u_decode (
    .clk        (clk),
    .rst        (rst),
    .inhibit    (inhibit_q),
    .enable_ok  (enable_ok),
    .start_pulse(start_pulse),
    .cmd_pulse  (cmd_pulse),
    .cmd_code   (cmd_code),
    .data_pulse (data_pulse),
    .stop_pulse (stop_pulse),
    .op_req     (op_req)
  );

  cfg_dur_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .running (t_running),
    .expire  (t_expire)
  );

  assign nv_we = t_expire && (op_q == OP_SAVE);

  cfg_nv_store #(
    .W   (CFG_W),
    .LANE(LANE_W),
    .INIT(STORE_INIT)
  ) u_store (
    .clk  (clk),
    .we   (nv_we),
    .wdata(cfg_r),
    .rdata(nv_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r       <= '0;
      inhibit_q   <= 1'b1;
      boot_done_q <= 1'b0;
      op_q        <= OP_NONE;
    end else begin
      if (t_load) begin
        op_q      <= boot_go ? OP_BOOT : op_req;
        inhibit_q <= 1'b1;
      end
      if (t_expire) begin
        op_q      <= OP_NONE;
        inhibit_q <= 1'b0;
        if (op_q == OP_BOOT) boot_done_q <= 1'b1;
        if (op_q == OP_BOOT || op_q == OP_RESTORE) cfg_r <= nv_rdata;
      end
      if (prog_load && !inhibit_q) cfg_r <= prog_data;
    end
  end

  assign cfg_q       = cfg_r;
  assign ack_inhibit = inhibit_q;
  assign boot_done   = boot_done_q;

  p_zero_until_boot_r1: assert property (@(posedge clk) disable iff (rst)
    !boot_done_q |-> (cfg_r == '0));
  p_mute_until_boot_r1: assert property (@(posedge clk) disable iff (rst)
    !boot_done_q |-> inhibit_q);
  p_boot_release_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_done_q) |-> $fell(inhibit_q));
  p_rise_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (boot_done_q && $rose(inhibit_q)) |-> $past(stop_pulse));
  p_enable_rule_r6: assert property (@(posedge clk) disable iff (rst)
    (boot_done_q && $rose(inhibit_q)) |->
      ($past(pwr_up) && !$past(pll_disable) && !$past(cfg_r[HOLD_BIT])));
  p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (inhibit_q && $past(inhibit_q)) |-> $stable(cfg_r));
  p_timer_tracks_flag_r5: assert property (@(posedge clk) disable iff (rst)
    t_running |-> inhibit_q);
endmodule

// File: tb/cfg_store_ctrl_tb.sv
module cfg_store_ctrl_tb;
  localparam int BOOT_CYC = 40;
  localparam int SAVE_CYC = 30;
  localparam int REST_CYC = 20;
  localparam logic [7:0]  SAVE_C = 8'hA5;
  localparam logic [7:0]  REST_C = 8'h5A;
  localparam logic [95:0] INIT_V = 96'h0123_4567_89AB_CDEF_0011_2233;
  localparam logic [95:0] HOLD_M = 96'b1 << 57;
  localparam logic [95:0] VAL_A  = 96'h1111_2222_3333_4444_5555_6666 & ~HOLD_M;
  localparam logic [95:0] VAL_B  = 96'hDEAD_BEEF_CAFE_F00D_1234_5678 & ~HOLD_M;
  localparam logic [95:0] VAL_C  = 96'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F | HOLD_M;
  localparam logic [95:0] VAL_D  = 96'h7777_8888_9999_AAAA_BBBB_CCCC & ~HOLD_M;
  localparam logic [95:0] VAL_E  = 96'hFFFF_0000_FFFF_0000_FFFF_0000;
  localparam logic [95:0] VAL_F  = 96'h2468_ACE0_1357_9BDF_0246_8ACE | HOLD_M;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_up = 1'b0, pll_disable = 1'b0;
  logic        start_pulse = 1'b0, cmd_pulse = 1'b0, data_pulse = 1'b0, stop_pulse = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        prog_load = 1'b0;
  logic [95:0] prog_data = '0;
  logic [95:0] cfg_q;
  logic        ack_inhibit, boot_done;

  int    n_cmp = 0, n_mis = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cfg_store_ctrl #(
    .BOOT_CYC(BOOT_CYC), .SAVE_CYC(SAVE_CYC), .RESTORE_CYC(REST_CYC),
    .SAVE_CODE(SAVE_C), .RESTORE_CODE(REST_C), .STORE_INIT(INIT_V)
  ) u_dut (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .pll_disable(pll_disable),
    .start_pulse(start_pulse), .cmd_pulse(cmd_pulse), .cmd_code(cmd_code),
    .data_pulse(data_pulse), .stop_pulse(stop_pulse),
    .prog_load(prog_load), .prog_data(prog_data),
    .cfg_q(cfg_q), .ack_inhibit(ack_inhibit), .boot_done(boot_done)
  );

  // Behavioural reference: remaining-cycle counter and an operation number.
  logic [95:0] m_cfg = '0;
  logic [95:0] m_nv = INIT_V;
  logic [7:0]  m_code = '0;
  bit m_inh = 1'b1, m_boot = 1'b0, m_arm = 1'b0, hit;
  int m_left = 0, m_op = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_inh = 1'b1; m_boot = 1'b0; m_arm = 1'b0; m_left = 0; m_op = 0;
    end else if (m_inh) begin
      m_arm = 1'b0;
      if (m_op != 0) begin
        if (m_left == 1) begin
          if (m_op == 1) m_nv = m_cfg;
          else m_cfg = m_nv;
          if (m_op == 3) m_boot = 1'b1;
          m_op = 0; m_left = 0; m_inh = 1'b0;
        end else m_left = m_left - 1;
      end else if (!m_boot && pwr_up) begin
        m_op = 3; m_left = BOOT_CYC;
      end
    end else begin
      hit = stop_pulse && m_arm && pwr_up && !pll_disable && !m_cfg[57] &&
            (m_code == SAVE_C || m_code == REST_C);
      if (prog_load) m_cfg = prog_data;
      if (hit) begin
        m_op = (m_code == SAVE_C) ? 1 : 2;
        m_left = (m_code == SAVE_C) ? SAVE_CYC : REST_CYC;
        m_inh = 1'b1;
      end
      if (start_pulse || data_pulse || stop_pulse) m_arm = 1'b0;
      else if (cmd_pulse) begin m_arm = 1'b1; m_code = cmd_code; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      n_cmp++;
      if (cfg_q !== m_cfg || ack_inhibit !== m_inh || boot_done !== m_boot) begin
        n_mis++;
        $display("FAIL %s model cycle %0d: got cfg=%h inh=%b bd=%b exp cfg=%h inh=%b bd=%b",
                 cur_req, cyc, cfg_q, ack_inhibit, boot_done, m_cfg, m_inh, m_boot);
      end
    end
    if (cyc > 100000) begin
      n_mis++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_mis++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_word(input logic [95:0] v);
    prog_load = 1'b1; prog_data = v;
    @(negedge clk);
    prog_load = 1'b0;
  endtask

  // START, command byte, optional data byte, STOP; returns just after STOP edge.
  task automatic send_cmd(input logic [7:0] code, input bit with_data, input bit restart);
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    cmd_pulse = 1'b1; cmd_code = code; @(negedge clk); cmd_pulse = 1'b0;
    if (with_data) begin data_pulse = 1'b1; @(negedge clk); data_pulse = 1'b0; end
    if (restart) begin start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0; end
    stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (ack_inhibit && n < 5000) begin n++; @(negedge clk); end
  endtask

  int n;

  initial begin
    tick(3);
    rst = 1'b0;
    cur_req = "R1";
    tick(4);
    chk("R1", cfg_q, '0);
    chk("R1", {95'b0, ack_inhibit}, 96'd1);
    load_word(VAL_A);
    tick(1);
    chk("R1", cfg_q, '0);

    cur_req = "R2";
    pll_disable = 1'b1;
    pwr_up = 1'b1;
    @(negedge clk);
    busy_len(n);
    chk("R2", 96'(n), 96'(BOOT_CYC));
    chk("R2", cfg_q, INIT_V);
    chk("R2", {95'b0, boot_done}, 96'd1);
    pll_disable = 1'b0;

    cur_req = "R3";
    load_word(VAL_A);
    chk("R3", cfg_q, VAL_A);

    cur_req = "R4";
    send_cmd(SAVE_C, 1'b0, 1'b0);
    busy_len(n);
    chk("R4", 96'(n), 96'(SAVE_CYC));

    cur_req = "R5";
    load_word(VAL_B);
    send_cmd(REST_C, 1'b0, 1'b0);
    tick(5);
    chk("R5", cfg_q, VAL_B);
    busy_len(n);
    chk("R5", 96'(n), 96'(REST_CYC - 5));
    chk("R5", cfg_q, VAL_A);

    cur_req = "R6";
    load_word(VAL_C);
    send_cmd(SAVE_C, 1'b0, 1'b0);
    chk("R6", {95'b0, ack_inhibit}, 96'd0);
    load_word(VAL_D);
    pwr_up = 1'b0;
    send_cmd(REST_C, 1'b0, 1'b0);
    chk("R6", {95'b0, ack_inhibit}, 96'd0);
    pwr_up = 1'b1; pll_disable = 1'b1;
    send_cmd(REST_C, 1'b0, 1'b0);
    chk("R6", {95'b0, ack_inhibit}, 96'd0);
    chk("R6", cfg_q, VAL_D);
    pll_disable = 1'b0;

    cur_req = "R7";
    send_cmd(8'h33, 1'b0, 1'b0);
    chk("R7", {95'b0, ack_inhibit}, 96'd0);
    send_cmd(REST_C, 1'b1, 1'b0);
    chk("R7", {95'b0, ack_inhibit}, 96'd0);
    send_cmd(REST_C, 1'b0, 1'b1);
    chk("R7", {95'b0, ack_inhibit}, 96'd0);
    chk("R7", cfg_q, VAL_D);

    cur_req = "R8";
    send_cmd(SAVE_C, 1'b0, 1'b0);
    tick(2);
    load_word(VAL_E);
    cmd_pulse = 1'b1; cmd_code = REST_C; @(negedge clk); cmd_pulse = 1'b0;
    busy_len(n);
    chk("R8", cfg_q, VAL_D);
    stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
    chk("R8", {95'b0, ack_inhibit}, 96'd0);

    cur_req = "R9";
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    cmd_pulse = 1'b1; cmd_code = SAVE_C; @(negedge clk); cmd_pulse = 1'b0;
    stop_pulse = 1'b1; prog_load = 1'b1; prog_data = VAL_F;
    @(negedge clk);
    stop_pulse = 1'b0; prog_load = 1'b0;
    chk("R9", {95'b0, ack_inhibit}, 96'd1);
    chk("R9", cfg_q, VAL_F);
    busy_len(n);
    chk("R9", 96'(n), 96'(SAVE_CYC));

    cur_req = "R10";
    rst = 1'b1; tick(2); rst = 1'b0;
    pll_disable = 1'b1;
    tick(1);
    busy_len(n);
    chk("R10", cfg_q, VAL_F);
    chk("R10", {95'b0, boot_done}, 96'd1);
    tick(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule